// File: doc/BRIEF.md
# Error-Correcting Word Memory with Hardware Clear and Raw Test Access

This block holds an array of 32-bit words, each stored together with a 7-bit single-error-correcting, double-error-detecting check field. A CPU-side request channel carries reads and writes. A read returns its data one cycle after the request is taken, together with flags that report a corrected error or an error that could not be corrected.

A hardware sweep, started by a one-cycle pulse, sets every word to zero with matching check bits. A sticky status output shows that at least one sweep has finished since reset. A 2-bit test-mode input lets software do three things: write the data field alone, write the check field alone, and read the raw check field, which makes fault injection and code inspection possible.

The request channel uses valid/ready handshaking. A request is taken on a rising edge where both `req_valid` and `req_ready` are high. The requester must hold the request stable until it is taken. `req_ready` is low only while a sweep is running. The response side has no back-pressure: `rsp_valid` pulses for exactly one cycle, and the consumer must capture the response in that cycle.

Top module: `ecc_ram_wrap`

## Requirements
- R1: After reset, `init_done`, `rsp_valid`, `err_corr` and `err_uncorr` are 0, and `req_ready` is 1.
- R2: With `test_mode` at 0 or 3, a write stores both the data and its generated check bits. A read of an error-free word returns that data with both error flags at 0.
- R3: In mode 0 or 3, if the stored word has one flipped bit in either the data or the check field, the read returns the corrected data and raises `err_corr` for the response cycle only.
- R4: In mode 0 or 3, if the stored word has two flipped bits, the read returns the stored data unchanged and raises `err_uncorr` for the response cycle only.
- R5: With `test_mode` at 1, a write replaces only the data field and leaves the stored check bits unchanged. A read returns the stored data uncorrected, with both flags at 0.
- R6: With `test_mode` at 2, a write replaces only the check field, using `req_wdata[6:0]`, and leaves the data unchanged. A read returns the stored check bits in `rsp_rdata[6:0]` with bits 31:7 at 0 and both flags at 0.
- R7: A pulse on `init_start` while idle starts a sweep. The sweep writes zero data with valid check bits to addresses 0 through 2^ADDR_W-1 in ascending order, one address per cycle. `req_ready` stays low for exactly 2^ADDR_W cycles.
- R8: `init_done` goes to 1 when a sweep ends. It then stays 1 through later sweeps and returns to 0 only on reset.
- R9: The check field is defined as follows. Data bit i occupies the i-th position, in ascending order, among the positions 1 to 38 that are not powers of two. Check bit j, for j from 0 to 5, is the XOR of the data bits whose position has bit j set. Check bit 6 is the XOR of all 32 data bits and check bits 0 to 5.
- R10: A read takes its mode from the value `test_mode` has in the cycle the read is taken. A change of `test_mode` after that cycle does not alter the response.
- R11: `rsp_valid` pulses exactly in the cycle after a read is taken. Writes and idle cycles produce no response.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Request can be taken; low while a sweep runs |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | ADDR_W | Word address |
| req_wdata | input | 32 | Write data; bits 6:0 are the check value in mode 2 |
| test_mode | input | 2 | 0/3 normal, 1 data-only raw, 2 check-only raw |
| init_start | input | 1 | One-cycle pulse that starts the clearing sweep |
| init_done | output | 1 | Sticky: a sweep has completed since reset |
| rsp_valid | output | 1 | Read response present (one cycle) |
| rsp_rdata | output | 32 | Read data, or raw check bits in mode 2 |
| err_corr | output | 1 | Single-bit error corrected in this response |
| err_uncorr | output | 1 | Double-bit error detected in this response |

## Verification
The assertions assume that the request inputs are known and stable once reset is released. They also assume that `init_start` is a single-cycle pulse and that no word is read before it has been written or swept, because unwritten storage holds unknown values. The stimulus runs a full sweep before any read. It injects faults only through the mode 1 and mode 2 writes, keeps every request held until it is taken, and changes `test_mode` only between requests, with one deliberate exception right after a read is taken.

// File: rtl/ecc_ram_pkg.sv
package ecc_ram_pkg;
  localparam int DATA_W    = 32;
  localparam int CHK_W     = 7;
  localparam int HAM_W     = 6;
  localparam int CODE_LAST = 38;

  typedef enum logic [1:0] {
    TM_NORMAL    = 2'd0,
    TM_RAW_DATA  = 2'd1,
    TM_RAW_CHECK = 2'd2,
    TM_NORMAL_B  = 2'd3
  } tmode_e;

  // Hamming part of the check field: XOR of the positions of all set data bits
  function automatic logic [HAM_W-1:0] ham_bits(input logic [DATA_W-1:0] d);
    logic [HAM_W-1:0] acc;
    int k;
    acc = '0;
    k = 0;
    for (int p = 1; p <= CODE_LAST; p++) begin
      if ((p & (p - 1)) != 0) begin
        if (d[k]) acc = acc ^ p[HAM_W-1:0];
        k++;
      end
    end
    return acc;
  endfunction

  // Data bit to invert for a given syndrome (zero when it names a check bit)
  function automatic logic [DATA_W-1:0] flip_mask(input logic [HAM_W-1:0] syn);
    logic [DATA_W-1:0] m;
    int k;
    m = '0;
    k = 0;
    for (int p = 1; p <= CODE_LAST; p++) begin
      if ((p & (p - 1)) != 0) begin
        if (syn == p[HAM_W-1:0]) m[k] = 1'b1;
        k++;
      end
    end
    return m;
  endfunction
endpackage

// File: rtl/secded_enc.sv
module secded_enc
  import ecc_ram_pkg::*;
(
  input  logic [DATA_W-1:0] data,
  output logic [CHK_W-1:0]  chk
);
  logic [HAM_W-1:0] ham;
  always_comb begin
    ham = ham_bits(data);
    chk = {(^data) ^ (^ham), ham};
  end
endmodule

// File: rtl/secded_dec.sv
module secded_dec
  import ecc_ram_pkg::*;
(
  input  logic              check_en,
  input  logic [DATA_W-1:0] data_in,
  input  logic [CHK_W-1:0]  chk_in,
  output logic [DATA_W-1:0] data_out,
  output logic              single_err,
  output logic              double_err
);
  logic [HAM_W-1:0] syn;
  logic             par;

  always_comb begin
    syn        = ham_bits(data_in) ^ chk_in[HAM_W-1:0];
    par        = (^data_in) ^ (^chk_in);
    data_out   = data_in;
    single_err = 1'b0;
    double_err = 1'b0;
    if (check_en) begin
      if (par) begin
        if (int'(syn) <= CODE_LAST) begin
          single_err = 1'b1;
          data_out   = data_in ^ flip_mask(syn);
        end else begin
          double_err = 1'b1;
        end
      end else if (syn != '0) begin
        double_err = 1'b1;
      end
    end
  end
endmodule

// File: rtl/ecc_ram_array.sv
module ecc_ram_array
  import ecc_ram_pkg::*;
#(
  parameter int ADDR_W = 6
) (
  input  logic              clk,
  input  logic              we_data,
  input  logic              we_chk,
  input  logic [ADDR_W-1:0] waddr,
  input  logic [DATA_W-1:0] wdata,
  input  logic [CHK_W-1:0]  wchk,
  input  logic              re,
  input  logic [ADDR_W-1:0] raddr,
  output logic [DATA_W-1:0] rdata,
  output logic [CHK_W-1:0]  rchk
);
  localparam int DEPTH = 1 << ADDR_W;

  logic [DATA_W-1:0] data_mem [DEPTH];
  logic [CHK_W-1:0]  chk_mem  [DEPTH];

  always_ff @(posedge clk) begin
    if (we_data) data_mem[waddr] <= wdata;
    if (we_chk)  chk_mem[waddr]  <= wchk;
  end

  always_ff @(posedge clk) begin
    if (re) begin
      rdata <= data_mem[raddr];
      rchk  <= chk_mem[raddr];
    end
  end
endmodule

// File: rtl/init_seq.sv
module init_seq #(
  parameter int ADDR_W = 6
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  output logic              busy,
  output logic [ADDR_W-1:0] addr,
  output logic              done
);
  localparam logic [ADDR_W-1:0] LAST = '1;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy <= 1'b0;
      addr <= '0;
      done <= 1'b0;
    end else if (busy) begin
      if (addr == LAST) begin
        busy <= 1'b0;
        done <= 1'b1;
      end else begin
        addr <= addr + 1'b1;
      end
    end else if (start) begin
      busy <= 1'b1;
      addr <= '0;
    end
  end

  AST_SWEEP_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && addr != LAST) |=> (busy && addr == $past(addr) + 1'b1)); // R7
  AST_SWEEP_END: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && addr == LAST) |=> (!busy && done)); // R8
  AST_DONE_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> done); // R8
endmodule

// File: rtl/ecc_ram_wrap.sv
module ecc_ram_wrap
  import ecc_ram_pkg::*;
#(
  parameter int ADDR_W = 6
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic              req_write,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [31:0]       req_wdata,
  input  logic [1:0]        test_mode,
  input  logic              init_start,
  output logic              init_done,
  output logic              rsp_valid,
  output logic [31:0]       rsp_rdata,
  output logic              err_corr,
  output logic              err_uncorr
);
  logic              sweep_busy;
  logic [ADDR_W-1:0] sweep_addr;
  logic              take;
  tmode_e            cur_mode;
  tmode_e            rd_mode_q;
  logic              rsp_q;

  logic [DATA_W-1:0] enc_in;
  logic [CHK_W-1:0]  enc_chk;
  logic              we_data, we_chk;
  logic [ADDR_W-1:0] waddr;
  logic [DATA_W-1:0] wdata;
  logic [CHK_W-1:0]  wchk;
  logic [DATA_W-1:0] arr_data;
  logic [CHK_W-1:0]  arr_chk;
  logic [DATA_W-1:0] dec_data;
  logic              dec_single, dec_double, check_en;

  init_seq #(.ADDR_W(ADDR_W)) i_init_seq (
    .clk   (clk),
    .rst_n (rst_n),
    .start (init_start),
    .busy  (sweep_busy),
    .addr  (sweep_addr),
    .done  (init_done)
  );

  assign req_ready = !sweep_busy;
  assign take      = req_valid && req_ready;
  assign cur_mode  = tmode_e'(test_mode);

  // write port: the sweep owns it while running
  always_comb begin
    enc_in  = sweep_busy ? '0 : req_wdata;
    waddr   = sweep_busy ? sweep_addr : req_addr;
    wdata   = enc_in;
    we_data = sweep_busy || (take && req_write && cur_mode != TM_RAW_CHECK);
    we_chk  = sweep_busy || (take && req_write && cur_mode != TM_RAW_DATA);
    wchk    = (!sweep_busy && cur_mode == TM_RAW_CHECK) ? req_wdata[CHK_W-1:0] : enc_chk;
  end

  secded_enc i_enc (
    .data (enc_in),
    .chk  (enc_chk)
  );

  ecc_ram_array #(.ADDR_W(ADDR_W)) i_array (
    .clk     (clk),
    .we_data (we_data),
    .we_chk  (we_chk),
    .waddr   (waddr),
    .wdata   (wdata),
    .wchk    (wchk),
    .re      (take && !req_write),
    .raddr   (req_addr),
    .rdata   (arr_data),
    .rchk    (arr_chk)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rsp_q     <= 1'b0;
      rd_mode_q <= TM_NORMAL;
    end else begin
      rsp_q <= take && !req_write;
      if (take && !req_write) rd_mode_q <= cur_mode;
    end
  end

  assign check_en = (rd_mode_q == TM_NORMAL) || (rd_mode_q == TM_NORMAL_B);

  secded_dec i_dec (
    .check_en   (check_en),
    .data_in    (arr_data),
    .chk_in     (arr_chk),
    .data_out   (dec_data),
    .single_err (dec_single),
    .double_err (dec_double)
  );

  assign rsp_valid  = rsp_q;
  assign rsp_rdata  = (rd_mode_q == TM_RAW_CHECK) ? {{(DATA_W-CHK_W){1'b0}}, arr_chk} : dec_data;
  assign err_corr   = rsp_q && dec_single;
  assign err_uncorr = rsp_q && dec_double;

  AST_SWEEP_BLOCKS: assert property (@(posedge clk) disable iff (!rst_n)
    (init_start && req_ready) |=> !req_ready); // R7
  AST_READ_RSP: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready && !req_write) |=> rsp_valid); // R11
  AST_NO_SPURIOUS_RSP: assert property (@(posedge clk) disable iff (!rst_n)
    !(req_valid && req_ready && !req_write) |=> !rsp_valid); // R11
  AST_FLAGS_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
    !(err_corr && err_uncorr)); // R3
  AST_FLAGS_WITH_RSP: assert property (@(posedge clk) disable iff (!rst_n)
    (err_corr || err_uncorr) |-> rsp_valid); // R4
  AST_RAW_NO_FLAGS: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready && !req_write && (test_mode == 2'd1 || test_mode == 2'd2))
    |=> (!err_corr && !err_uncorr)); // R5
  AST_RAWCHK_UPPER_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready && !req_write && test_mode == 2'd2)
    |=> (rsp_rdata[31:7] == '0)); // R6
endmodule

// File: tb/test_ecc_ram_wrap.sv
module test_ecc_ram_wrap;
  localparam int CLK_PERIOD = 10;
  localparam int ADDR_W     = 6;
  localparam int DEPTH      = 1 << ADDR_W;
  localparam int NVEC       = 12;

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic              req_valid = 1'b0;
  logic              req_ready;
  logic              req_write = 1'b0;
  logic [ADDR_W-1:0] req_addr = '0;
  logic [31:0]       req_wdata = '0;
  logic [1:0]        test_mode = 2'd0;
  logic              init_start = 1'b0;
  logic              init_done;
  logic              rsp_valid;
  logic [31:0]       rsp_rdata;
  logic              err_corr;
  logic              err_uncorr;

  int checks = 0;
  int errors = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  ecc_ram_wrap #(.ADDR_W(ADDR_W)) i_ecc_ram_wrap (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_write(req_write), .req_addr(req_addr), .req_wdata(req_wdata),
    .test_mode(test_mode), .init_start(init_start), .init_done(init_done),
    .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata), .err_corr(err_corr),
    .err_uncorr(err_uncorr)
  );

  // reference check field built from the R9 position rule
  function automatic logic [6:0] ref_chk(input logic [31:0] d);
    logic [5:0] s;
    int bi;
    s = '0;
    bi = 0;
    for (int pos = 3; pos <= 38; pos++) begin
      if ($countones(pos) != 1) begin
        if (d[bi]) s = s ^ pos[5:0];
        bi++;
      end
    end
    return {(^d) ^ (^s), s};
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // one request; for reads the response is sampled in the cycle after acceptance
  task automatic do_req(input logic [1:0] m, input logic w, input logic [ADDR_W-1:0] a,
                        input logic [31:0] d, input logic flip_mode,
                        output logic [31:0] rd, output logic c, output logic u, output logic v);
    @(negedge clk);
    test_mode = m; req_write = w; req_addr = a; req_wdata = d; req_valid = 1'b1;
    while (!req_ready) @(negedge clk);
    @(posedge clk);
    #1;
    if (flip_mode) test_mode = 2'd0;
    @(negedge clk);
    req_valid = 1'b0;
    rd = rsp_rdata; c = err_corr; u = err_uncorr; v = rsp_valid;
  endtask

  task automatic run_sweep(output int low_cycles);
    @(negedge clk);
    init_start = 1'b1;
    @(posedge clk);
    @(negedge clk);
    init_start = 1'b0;
    low_cycles = 0;
    while (!req_ready && low_cycles < 4 * DEPTH) begin
      low_cycles++;
      @(negedge clk);
    end
  endtask

  // {mode, write, addr, wdata, expected data, exp corr, exp uncorr, expect ref_chk(exp data)}
  localparam logic [75:0] VEC [NVEC] = '{
    {2'd0, 1'b1, 6'd1, 32'hA5A5_1234, 32'h0, 1'b0, 1'b0, 1'b0},  // R2 write
    {2'd0, 1'b0, 6'd1, 32'h0, 32'hA5A5_1234, 1'b0, 1'b0, 1'b0},  // R2 read
    {2'd3, 1'b1, 6'd2, 32'h0000_0001, 32'h0, 1'b0, 1'b0, 1'b0},  // R2 mode 3 write
    {2'd3, 1'b0, 6'd2, 32'h0, 32'h0000_0001, 1'b0, 1'b0, 1'b0},  // R2 mode 3 read
    {2'd2, 1'b0, 6'd1, 32'h0, 32'hA5A5_1234, 1'b0, 1'b0, 1'b1},  // R6 R9 raw check
    {2'd1, 1'b1, 6'd1, 32'hA5A5_1334, 32'h0, 1'b0, 1'b0, 1'b0},  // R5 data-only write
    {2'd1, 1'b0, 6'd1, 32'h0, 32'hA5A5_1334, 1'b0, 1'b0, 1'b0},  // R5 raw read
    {2'd0, 1'b0, 6'd1, 32'h0, 32'hA5A5_1234, 1'b1, 1'b0, 1'b0},  // R3 corrected
    {2'd1, 1'b1, 6'd1, 32'h25A5_1235, 32'h0, 1'b0, 1'b0, 1'b0},  // R4 two flips
    {2'd0, 1'b0, 6'd1, 32'h0, 32'h25A5_1235, 1'b0, 1'b1, 1'b0},  // R4 detected
    {2'd2, 1'b0, 6'd1, 32'h0, 32'hA5A5_1234, 1'b0, 1'b0, 1'b1},  // R5 check kept
    {2'd0, 1'b0, 6'd5, 32'h0, 32'h0000_0000, 1'b0, 1'b0, 1'b0}   // R7 swept word
  };

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin : main
    logic [31:0] rd;
    logic c, u, v;
    int lowc;
    logic [31:0] expd;

    repeat (3) @(posedge clk);
    @(negedge clk);
    chk("R1 init_done", {31'b0, init_done}, 32'h0);
    chk("R1 req_ready", {31'b0, req_ready}, 32'h1);
    chk("R1 rsp/flags", {29'b0, rsp_valid, err_corr, err_uncorr}, 32'h0);
    rst_n = 1'b1;

    run_sweep(lowc);
    chk("R7 ready low cycles", lowc, DEPTH);
    chk("R8 done after sweep", {31'b0, init_done}, 32'h1);

    for (int i = 0; i < NVEC; i++) begin
      do_req(VEC[i][75:74], VEC[i][73], VEC[i][72:67], VEC[i][66:35], 1'b0, rd, c, u, v);
      if (!VEC[i][73]) begin
        expd = VEC[i][0] ? {25'b0, ref_chk(VEC[i][34:3])} : VEC[i][34:3];
        chk($sformatf("R2-R7 vec%0d data", i), rd, expd);
        chk($sformatf("R11 vec%0d valid/R3 R4 flags", i), {29'b0, v, c, u},
            {29'b0, 1'b1, VEC[i][2], VEC[i][1]});
      end
    end

    // R6: check-only write of a one-bit-off check field, upper write bits ignored
    expd = {25'b0, ref_chk(32'h0000_0001) ^ 7'h01};
    do_req(2'd2, 1'b1, 6'd2, 32'hFFFF_FF80 | expd, 1'b0, rd, c, u, v);
    do_req(2'd2, 1'b0, 6'd2, 32'h0, 1'b0, rd, c, u, v);
    chk("R6 raw check after write", rd, expd);
    do_req(2'd0, 1'b0, 6'd2, 32'h0, 1'b0, rd, c, u, v);
    chk("R6 data kept / R3 check-bit error corrected", rd, 32'h0000_0001);
    chk("R3 flag for check-bit error", {30'b0, c, u}, 32'h2);

    // R10: mode changed right after acceptance does not alter response
    do_req(2'd2, 1'b0, 6'd1, 32'h0, 1'b1, rd, c, u, v);
    chk("R10 mode held for response", rd, {25'b0, ref_chk(32'hA5A5_1234)});

    // R11: write and idle cycles give no response
    do_req(2'd0, 1'b1, 6'd9, 32'h1234_5678, 1'b0, rd, c, u, v);
    chk("R11 no response to write", {31'b0, v}, 32'h0);
    @(negedge clk);
    chk("R11 idle no response", {31'b0, rsp_valid}, 32'h0);

    // R8: second sweep keeps init_done and clears written words
    run_sweep(lowc);
    chk("R7 second sweep length", lowc, DEPTH);
    chk("R8 done stays high", {31'b0, init_done}, 32'h1);
    do_req(2'd0, 1'b0, 6'd9, 32'h0, 1'b0, rd, c, u, v);
    chk("R7 word cleared by sweep", rd, 32'h0);
    do_req(2'd2, 1'b0, 6'd63, 32'h0, 1'b0, rd, c, u, v);
    chk("R7 R9 last word check bits", rd, {25'b0, ref_chk(32'h0)});

    // R8: only reset clears done
    @(negedge clk);
    rst_n = 1'b0;
    @(posedge clk);
    @(negedge clk);
    chk("R8 done cleared by reset", {31'b0, init_done}, 32'h0);
    chk("R1 ready after reset", {31'b0, req_ready}, 32'h1);

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule